// File: doc/BRIEF.md
# PCI-to-PCI Bridge Address Window Decoder

This block holds the base and limit fields of a type-1 configuration header and turns them into three address windows: I/O, non-prefetchable memory and prefetchable memory. A 64-bit transaction address and a space selector are presented on a lookup stream. One cycle after the lookup is accepted, the block returns a hit flag that says whether the address falls inside the selected window and so belongs on the secondary side.

The configuration port is a plain dword-addressed write/read port with byte enables. Reads are combinational. A write lands on the clock edge where `cfg_wr` is high. Any write whose enabled bytes overlap the window fields causes a one-cycle `remap` pulse in the following cycle, so that the logic around the block knows the windows have moved. Each window has its own packing and granularity. I/O uses 4 KB steps and may extend to 32 bits. Memory uses 1 MB steps and is 32-bit. Prefetchable memory uses 1 MB steps and may extend to 64 bits. The extensions are chosen by parameters and show up as read-only type nibbles.

The lookup side is a one-deep valid/ready stage. `lk_ready` is high whenever no result is pending or the pending result is being taken in the same cycle. A result that the consumer holds off with `res_ready` low stays on `res_valid`/`res_hit` unchanged.

Top module: `pcib_window_dec`

## Requirements
- R1: After reset, every window field is zero and no result is pending. `remap` is low and `lk_ready` is high. With zero fields, I/O addresses 0x0..0xFFF and memory addresses 0x0..0xFFFFF hit, and I/O address 0x1000 misses.
- R2: The I/O base is the upper nibble of byte 0x1C placed at address bits [15:12], with bits [11:0] zero. The I/O limit is built the same way from byte 0x1D, with bits [11:0] forced to ones. When IO32=1 the type nibble reads 1, and the 16-bit fields at 0x30 (base) and 0x32 (limit) supply bits [31:16]. When IO32=0 those bits are zero.
- R3: The memory base is bits [15:4] of the 16-bit field at 0x20, placed at address bits [31:20]. The memory limit is built the same way from 0x22, with bits [19:0] forced to ones. Address bits [63:32] of both are zero.
- R4: The prefetchable base and limit use the memory packing at 0x24 and 0x26. When PREF64=1 the type nibble reads 1, and the 32-bit fields at 0x28 (base) and 0x2C (limit) supply bits [63:32].
- R5: The space codes are 0 for I/O, 1 for memory, 2 for prefetchable, and 3 for none. A lookup hits when base <= address <= limit, inclusive at both ends. A window whose base exceeds its limit never hits, and code 3 never hits.
- R6: A write changes only the bytes whose enable is set. The low nibbles of bytes 0x1C, 0x1D, 0x24 and 0x26 always read as the type code. The low nibbles of bytes 0x20 and 0x22 always read 0.
- R7: Read-back of the fixed fields:
  - dword 0 is {DEV_ID, VEN_ID}.
  - dword 1 bits [31:16] are 0x00A0 (66 MHz capable and fast back-to-back).
  - dword 2 is 0x06040000.
  - dword 3 bits [23:16] are {MULTI_FN, 7'h01}.
  - dword 7 bits [31:16] are 0x00A0.
  - Unimplemented dwords read 0.
- R8: `remap` is high for exactly the cycle after a write in which at least one enabled byte lies in 0x1C..0x1D or 0x20..0x33. No other write raises it.
- R9: `lk_ready` equals (not `res_valid`) or `res_ready`. While `res_valid` is high and `res_ready` is low, `res_valid` and `res_hit` hold.
- R10: A lookup accepted at a clock edge yields `res_valid` in the next cycle. Its hit uses the window fields as they stood before that edge, even if a write lands on the same edge.
- R11: Writes to the identification, status, class, header and unimplemented dwords do not change anything that is read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration dword address |
| cfg_be | input | 4 | Write byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data for `cfg_addr` |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high with `lk_valid` |
| lk_addr | input | 64 | Lookup address |
| lk_space | input | 2 | Space selector: 0 I/O, 1 memory, 2 prefetchable, 3 none |
| res_valid | output | 1 | Lookup result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_hit | output | 1 | Address lies inside the selected window |
| remap | output | 1 | One-cycle pulse after a write that touches window fields |

## Verification
The assertions assume that `cfg_wr`, `cfg_be`, `lk_valid` and `res_ready` are known values once reset is released. They also assume that a consumer holding `res_ready` low does not expect the pending result to change. The stimulus drives every input on the falling edge, from a defined idle value. It keeps `res_ready` high except in the one back-pressure scenario, where it is lowered and raised again between edges. The lookups cover each window's first and last address and the addresses just outside them, including wrap below address zero. This makes the inclusive comparison and the disabled-window case observable at the hit flag.

// File: rtl/pcib_win_pkg.sv
package pcib_win_pkg;

  localparam int ADDR_W = 64;

  // dword indexes of the configuration fields
  localparam int DW_ID    = 0;
  localparam int DW_STS   = 1;
  localparam int DW_CLS   = 2;
  localparam int DW_HDR   = 3;
  localparam int DW_IO    = 7;
  localparam int DW_MEM   = 8;
  localparam int DW_PF    = 9;
  localparam int DW_PFU_B = 10;
  localparam int DW_PFU_L = 11;
  localparam int DW_IOU   = 12;

  // byte spans that move a window
  localparam int IO_SPAN_LO  = 'h1C;
  localparam int IO_SPAN_HI  = 'h1D;
  localparam int MEM_SPAN_LO = 'h20;
  localparam int MEM_SPAN_HI = 'h33;

  localparam logic [15:0] STS_CAPS  = 16'h00A0;
  localparam logic [23:0] CLASS_P2P = 24'h060400;
  localparam logic [6:0]  HDR_P2P   = 7'h01;

  typedef enum logic [1:0] {
    SP_IO   = 2'd0,
    SP_MEM  = 2'd1,
    SP_PREF = 2'd2,
    SP_NONE = 2'd3
  } space_e;

  typedef struct packed {
    logic [3:0]  io_b;
    logic [3:0]  io_l;
    logic [11:0] mem_b;
    logic [11:0] mem_l;
    logic [11:0] pf_b;
    logic [11:0] pf_l;
    logic [31:0] pfu_b;
    logic [31:0] pfu_l;
    logic [15:0] iou_b;
    logic [15:0] iou_l;
  } win_regs_t;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
  } win_t;

endpackage

// File: rtl/pcib_cfg_regs.sv
module pcib_cfg_regs
  import pcib_win_pkg::*;
#(
  parameter int          CFG_AW   = 6,
  parameter logic [15:0] VEN_ID   = 16'h1B36,
  parameter logic [15:0] DEV_ID   = 16'h0001,
  parameter bit          MULTI_FN = 1'b0,
  parameter bit          IO32     = 1'b1,
  parameter bit          PREF64   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output win_regs_t         regs,
  output logic              remap
);

  localparam int          BYTE_AW = CFG_AW + 2;
  localparam logic [3:0]  IO_TY   = IO32   ? 4'h1 : 4'h0;
  localparam logic [3:0]  PF_TY   = PREF64 ? 4'h1 : 4'h0;

  logic [3:0]  io_b_q, io_l_q;
  logic [11:0] mem_b_q, mem_l_q, pf_b_q, pf_l_q;
  logic [31:0] pfu_b_q, pfu_l_q;
  logic [15:0] iou_b_q, iou_l_q;

  logic sel_io, sel_mem, sel_pf;
  assign sel_io  = cfg_wr && (cfg_addr == CFG_AW'(DW_IO));
  assign sel_mem = cfg_wr && (cfg_addr == CFG_AW'(DW_MEM));
  assign sel_pf  = cfg_wr && (cfg_addr == CFG_AW'(DW_PF));

  // 16-bit windows: only the address nibbles are storage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_b_q  <= '0;
      io_l_q  <= '0;
      mem_b_q <= '0;
      mem_l_q <= '0;
      pf_b_q  <= '0;
      pf_l_q  <= '0;
    end else begin
      if (sel_io) begin
        if (cfg_be[0]) io_b_q <= cfg_wdata[7:4];
        if (cfg_be[1]) io_l_q <= cfg_wdata[15:12];
      end
      if (sel_mem) begin
        if (cfg_be[0]) mem_b_q[3:0]  <= cfg_wdata[7:4];
        if (cfg_be[1]) mem_b_q[11:4] <= cfg_wdata[15:8];
        if (cfg_be[2]) mem_l_q[3:0]  <= cfg_wdata[23:20];
        if (cfg_be[3]) mem_l_q[11:4] <= cfg_wdata[31:24];
      end
      if (sel_pf) begin
        if (cfg_be[0]) pf_b_q[3:0]  <= cfg_wdata[7:4];
        if (cfg_be[1]) pf_b_q[11:4] <= cfg_wdata[15:8];
        if (cfg_be[2]) pf_l_q[3:0]  <= cfg_wdata[23:20];
        if (cfg_be[3]) pf_l_q[11:4] <= cfg_wdata[31:24];
      end
    end
  end

  // upper halves exist only when the extension is built
  generate
    if (PREF64) begin : g_pf64
      logic sel_pub, sel_pul;
      assign sel_pub = cfg_wr && (cfg_addr == CFG_AW'(DW_PFU_B));
      assign sel_pul = cfg_wr && (cfg_addr == CFG_AW'(DW_PFU_L));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pfu_b_q <= '0;
          pfu_l_q <= '0;
        end else begin
          for (int k = 0; k < 4; k++) begin
            if (sel_pub && cfg_be[k]) pfu_b_q[8*k +: 8] <= cfg_wdata[8*k +: 8];
            if (sel_pul && cfg_be[k]) pfu_l_q[8*k +: 8] <= cfg_wdata[8*k +: 8];
          end
        end
      end
    end else begin : g_pf32
      assign pfu_b_q = '0;
      assign pfu_l_q = '0;
    end

    if (IO32) begin : g_io32
      logic sel_iou;
      assign sel_iou = cfg_wr && (cfg_addr == CFG_AW'(DW_IOU));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          iou_b_q <= '0;
          iou_l_q <= '0;
        end else if (sel_iou) begin
          for (int k = 0; k < 2; k++) begin
            if (cfg_be[k])   iou_b_q[8*k +: 8] <= cfg_wdata[8*k +: 8];
            if (cfg_be[k+2]) iou_l_q[8*k +: 8] <= cfg_wdata[8*(k+2) +: 8];
          end
        end
      end
    end else begin : g_io16
      assign iou_b_q = '0;
      assign iou_l_q = '0;
    end
  endgenerate

  always_comb begin
    regs.io_b  = io_b_q;
    regs.io_l  = io_l_q;
    regs.mem_b = mem_b_q;
    regs.mem_l = mem_l_q;
    regs.pf_b  = pf_b_q;
    regs.pf_l  = pf_l_q;
    regs.pfu_b = pfu_b_q;
    regs.pfu_l = pfu_l_q;
    regs.iou_b = iou_b_q;
    regs.iou_l = iou_l_q;
  end

  // overlap of the enabled byte span with the window fields
  logic touch;
  always_comb begin
    touch = 1'b0;
    for (int i = 0; i < 4; i++) begin
      logic [BYTE_AW-1:0] ba;
      ba = {cfg_addr, 2'(i)};
      if (cfg_be[i] &&
          (((ba >= BYTE_AW'(IO_SPAN_LO))  && (ba <= BYTE_AW'(IO_SPAN_HI))) ||
           ((ba >= BYTE_AW'(MEM_SPAN_LO)) && (ba <= BYTE_AW'(MEM_SPAN_HI)))))
        touch = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) remap <= 1'b0;
    else        remap <= cfg_wr && touch;
  end

  // read mux
  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      CFG_AW'(DW_ID):    cfg_rdata = {DEV_ID, VEN_ID};
      CFG_AW'(DW_STS):   cfg_rdata = {STS_CAPS, 16'h0000};
      CFG_AW'(DW_CLS):   cfg_rdata = {CLASS_P2P, 8'h00};
      CFG_AW'(DW_HDR):   cfg_rdata = {8'h00, MULTI_FN, HDR_P2P, 16'h0000};
      CFG_AW'(DW_IO):    cfg_rdata = {STS_CAPS, io_l_q, IO_TY, io_b_q, IO_TY};
      CFG_AW'(DW_MEM):   cfg_rdata = {mem_l_q, 4'h0, mem_b_q, 4'h0};
      CFG_AW'(DW_PF):    cfg_rdata = {pf_l_q, PF_TY, pf_b_q, PF_TY};
      CFG_AW'(DW_PFU_B): cfg_rdata = pfu_b_q;
      CFG_AW'(DW_PFU_L): cfg_rdata = pfu_l_q;
      CFG_AW'(DW_IOU):   cfg_rdata = {iou_l_q, iou_b_q};
      default:           cfg_rdata = '0;
    endcase
  end

  // R8: a pulse always follows a write
  a_r8_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    remap |-> $past(cfg_wr));

  // R8: a write with no enabled byte never raises the pulse
  a_r8_no_pulse_be0: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (cfg_be == 4'h0)) |=> !remap);

endmodule

// File: rtl/pcib_win_calc.sv
module pcib_win_calc
  import pcib_win_pkg::*;
(
  input  win_regs_t regs,
  output win_t      io_w,
  output win_t      mem_w,
  output win_t      pf_w
);

  always_comb begin
    io_w.base   = {32'h0, regs.iou_b, regs.io_b, 12'h000};
    io_w.limit  = {32'h0, regs.iou_l, regs.io_l, 12'hFFF};
    mem_w.base  = {32'h0, regs.mem_b, 20'h00000};
    mem_w.limit = {32'h0, regs.mem_l, 20'hFFFFF};
    pf_w.base   = {regs.pfu_b, regs.pf_b, 20'h00000};
    pf_w.limit  = {regs.pfu_l, regs.pf_l, 20'hFFFFF};
  end

endmodule

// File: rtl/pcib_win_match.sv
module pcib_win_match
  import pcib_win_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  win_t              io_w,
  input  win_t              mem_w,
  input  win_t              pf_w,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [1:0]        lk_space,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit
);

  function automatic logic inside_win(input win_t w, input logic [ADDR_W-1:0] a);
    return (w.base <= w.limit) && (a >= w.base) && (a <= w.limit);
  endfunction

  logic hit_d;
  always_comb begin
    unique case (space_e'(lk_space))
      SP_IO:   hit_d = inside_win(io_w, lk_addr);
      SP_MEM:  hit_d = inside_win(mem_w, lk_addr);
      SP_PREF: hit_d = inside_win(pf_w, lk_addr);
      default: hit_d = 1'b0;
    endcase
  end

  assign lk_ready = !res_valid || res_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
    end else if (lk_valid && lk_ready) begin
      res_valid <= 1'b1;
      res_hit   <= hit_d;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R9: a stalled result holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hit)));

  // R10: an accepted lookup produces a result next cycle
  a_r10_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> res_valid);

  // R5: the reserved space code never hits
  a_r5_none_misses: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && (lk_space == 2'd3)) |=> !res_hit);

endmodule

// File: rtl/pcib_window_dec.sv
module pcib_window_dec
  import pcib_win_pkg::*;
#(
  parameter int          CFG_AW   = 6,
  parameter logic [15:0] VEN_ID   = 16'h1B36,
  parameter logic [15:0] DEV_ID   = 16'h0001,
  parameter bit          MULTI_FN = 1'b0,
  parameter bit          IO32     = 1'b1,
  parameter bit          PREF64   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [63:0]       lk_addr,
  input  logic [1:0]        lk_space,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic              remap
);

  win_regs_t regs;
  win_t      io_w, mem_w, pf_w;

  pcib_cfg_regs #(
    .CFG_AW  (CFG_AW),
    .VEN_ID  (VEN_ID),
    .DEV_ID  (DEV_ID),
    .MULTI_FN(MULTI_FN),
    .IO32    (IO32),
    .PREF64  (PREF64)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_addr (cfg_addr),
    .cfg_be   (cfg_be),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .regs     (regs),
    .remap    (remap)
  );

  pcib_win_calc u_calc (
    .regs (regs),
    .io_w (io_w),
    .mem_w(mem_w),
    .pf_w (pf_w)
  );

  pcib_win_match u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_w     (io_w),
    .mem_w    (mem_w),
    .pf_w     (pf_w),
    .lk_valid (lk_valid),
    .lk_ready (lk_ready),
    .lk_addr  (lk_addr),
    .lk_space (lk_space),
    .res_valid(res_valid),
    .res_ready(res_ready),
    .res_hit  (res_hit)
  );

endmodule

// File: tb/pcib_window_dec_tb.sv
`timescale 1ns/1ps
module pcib_window_dec_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [63:0] lk_addr = '0;
  logic [1:0]  lk_space = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_hit;
  logic        remap;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] sh [0:63];

  always #4 clk = ~clk;

  pcib_window_dec u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .lk_space(lk_space), .res_valid(res_valid), .res_ready(res_ready),
    .res_hit(res_hit), .remap(remap)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected windows from the requirement packing (R2, R3, R4)
  function automatic logic [63:0] w_base(input int sp);
    case (sp)
      0: return {32'h0, sh['h31], sh['h30], sh['h1C][7:4], 12'h0};
      1: return {32'h0, sh['h21], sh['h20][7:4], 20'h0};
      default: return {sh['h2B], sh['h2A], sh['h29], sh['h28], sh['h25], sh['h24][7:4], 20'h0};
    endcase
  endfunction
  function automatic logic [63:0] w_lim(input int sp);
    case (sp)
      0: return {32'h0, sh['h33], sh['h32], sh['h1D][7:4], 12'hFFF};
      1: return {32'h0, sh['h23], sh['h22][7:4], 20'hFFFFF};
      default: return {sh['h2F], sh['h2E], sh['h2D], sh['h2C], sh['h27], sh['h26][7:4], 20'hFFFFF};
    endcase
  endfunction
  function automatic bit exp_hit(input int sp, input logic [63:0] a);
    if (sp == 3) return 1'b0;
    return (w_base(sp) <= w_lim(sp)) && (a >= w_base(sp)) && (a <= w_lim(sp));
  endfunction
  function automatic logic [31:0] exp_rd(input int dw);
    case (dw)
      0: return 32'h0001_1B36;
      1: return 32'h00A0_0000;
      2: return 32'h0604_0000;
      3: return 32'h0001_0000;
      7: return {16'h00A0, sh['h1D][7:4], 4'h1, sh['h1C][7:4], 4'h1};
      8: return {sh['h23], sh['h22][7:4], 4'h0, sh['h21], sh['h20][7:4], 4'h0};
      9: return {sh['h27], sh['h26][7:4], 4'h1, sh['h25], sh['h24][7:4], 4'h1};
      10: return {sh['h2B], sh['h2A], sh['h29], sh['h28]};
      11: return {sh['h2F], sh['h2E], sh['h2D], sh['h2C]};
      12: return {sh['h33], sh['h32], sh['h31], sh['h30]};
      default: return 32'h0;
    endcase
  endfunction
  function automatic bit exp_touch(input int dw, input logic [3:0] be);
    for (int i = 0; i < 4; i++) begin
      int ba;
      ba = dw * 4 + i;
      if (be[i] && ((ba >= 'h1C && ba <= 'h1D) || (ba >= 'h20 && ba <= 'h33))) return 1'b1;
    end
    return 1'b0;
  endfunction

  // write at a falling edge, land on the next rising edge, check the pulse (R8)
  task automatic wr(input int dw, input logic [3:0] be, input logic [31:0] d);
    bit t;
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 6'(dw); cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
    t = exp_touch(dw, be);
    chk(remap == t, "R8 remap pulse", 64'(remap), 64'(t));
    for (int i = 0; i < 4; i++)
      if (be[i]) sh[(dw * 4 + i) % 64] = d[8*i +: 8];
  endtask

  task automatic rd(input int dw, input string req);
    cfg_addr = 6'(dw);
    #1;
    chk(cfg_rdata == exp_rd(dw), req, 64'(cfg_rdata), 64'(exp_rd(dw)));
  endtask

  task automatic look(input int sp, input logic [63:0] a, input string req);
    bit e;
    @(negedge clk);
    lk_valid = 1'b1; lk_space = 2'(sp); lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    e = exp_hit(sp, a);
    chk(res_valid == 1'b1, "R10 result valid next cycle", 64'(res_valid), 64'd1);
    chk(res_hit == e, req, 64'(res_hit), 64'(e));
  endtask

  task automatic edges(input int sp, input string req);
    logic [63:0] b, l;
    b = w_base(sp); l = w_lim(sp);
    look(sp, b, req);
    look(sp, b - 64'd1, req);
    look(sp, l, req);
    look(sp, l + 64'd1, req);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 64; i++) sh[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(remap == 1'b0, "R1 remap after reset", 64'(remap), 64'd0);
    chk(res_valid == 1'b0, "R1 no result after reset", 64'(res_valid), 64'd0);
    chk(lk_ready == 1'b1, "R1 ready after reset", 64'(lk_ready), 64'd1);
    for (int dw = 7; dw <= 12; dw++) rd(dw, "R1 window fields zero");
    look(0, 64'h0FFF, "R1 io hit at reset");
    look(0, 64'h1000, "R1 io miss at reset");
    look(1, 64'hFFFFF, "R1 mem hit at reset");

    // R7 fixed fields
    for (int dw = 0; dw < 16; dw++) rd(dw, "R7 read-back");

    // R2 I/O sweep over every base and limit nibble
    for (int b = 0; b < 16; b++)
      for (int l = 0; l < 16; l++) begin
        wr(7, 4'b0011, {16'hFFFF, 4'(l), 4'hF, 4'(b), 4'hF});
        rd(7, "R6 io type nibble");
        edges(0, "R2 io window edge");
      end
    // R2 with upper 16 bits
    wr(12, 4'b1111, 32'h0003_0001);
    rd(12, "R2 io upper read");
    edges(0, "R2 io upper edge");
    wr(12, 4'b1111, 32'h0001_0003);
    edges(0, "R5 io disabled by upper");

    // R3 memory sweep
    for (int b = 0; b < 8; b++)
      for (int l = 0; l < 8; l++) begin
        wr(8, 4'b1111, {12'((l * 'h235 + 7) % 4096), 4'hF, 12'((b * 'h235 + 5) % 4096), 4'hF});
        rd(8, "R6 mem low nibble");
        edges(1, "R3 mem window edge");
        look(1, 64'h1_0000_0000 | w_base(1), "R3 mem above 4G");
      end

    // R4 prefetchable with 64-bit upper halves
    for (int ub = 0; ub < 2; ub++)
      for (int ul = 0; ul < 3; ul++) begin
        wr(9, 4'b1111, 32'h0100_0FF0);
        wr(10, 4'b1111, 32'(ub));
        wr(11, 4'b1111, 32'(ul));
        rd(9, "R6 pref type nibble");
        edges(2, "R4 pref window edge");
        look(3, w_base(2), "R5 none space");
      end

    // R6 partial byte enables
    wr(8, 4'b0100, 32'hFFFF_FFFF);
    rd(8, "R6 single byte write");
    wr(10, 4'b0010, 32'hA5A5_A5A5);
    rd(10, "R6 upper byte write");
    wr(9, 4'b0000, 32'hFFFF_FFFF);
    rd(9, "R6 zero enables");

    // R8 remap over every dword and enable pattern
    for (int dw = 0; dw < 16; dw++)
      for (int be = 0; be < 16; be++)
        wr(dw, 4'(be), 32'h0);

    // R11 writes to fixed fields change nothing read back
    for (int dw = 0; dw < 7; dw++) wr(dw, 4'hF, 32'hFFFF_FFFF);
    for (int dw = 13; dw < 16; dw++) wr(dw, 4'hF, 32'hFFFF_FFFF);
    for (int i = 0; i < 28; i++) sh[i] = 8'h00;
    for (int i = 52; i < 64; i++) sh[i] = 8'h00;
    for (int dw = 0; dw < 16; dw++) rd(dw, "R11 fixed fields unchanged");

    // R10 lookup sees the windows from before a same-edge write
    wr(8, 4'b1111, 32'h0020_0010);
    @(negedge clk);
    lk_valid = 1'b1; lk_space = 2'd1; lk_addr = 64'h0010_0000;
    cfg_wr = 1'b1; cfg_addr = 6'd8; cfg_be = 4'hF; cfg_wdata = 32'h0030_0030;
    @(negedge clk);
    lk_valid = 1'b0; cfg_wr = 1'b0; cfg_be = '0;
    chk(res_hit == 1'b1, "R10 old window used", 64'(res_hit), 64'd1);
    sh['h20] = 8'h30; sh['h21] = 8'h00; sh['h22] = 8'h30; sh['h23] = 8'h00;
    look(1, 64'h0010_0000, "R10 new window after write");

    // R9 back-pressure
    @(negedge clk);
    res_ready = 1'b0;
    lk_valid = 1'b1; lk_space = 2'd1; lk_addr = 64'h0030_0000;
    @(negedge clk);
    lk_addr = 64'h0000_0000;
    chk(res_valid == 1'b1, "R9 first result", 64'(res_valid), 64'd1);
    chk(lk_ready == 1'b0, "R9 ready low when stalled", 64'(lk_ready), 64'd0);
    repeat (3) begin
      @(negedge clk);
      chk(res_valid == 1'b1 && res_hit == 1'b1, "R9 result held", 64'(res_hit), 64'd1);
    end
    res_ready = 1'b1;
    #1;
    chk(lk_ready == 1'b1, "R9 ready with consumer", 64'(lk_ready), 64'd1);
    @(negedge clk);
    lk_valid = 1'b0;
    chk(res_valid == 1'b1 && res_hit == 1'b0, "R9 second result", 64'(res_hit), 64'd0);
    @(negedge clk);
    chk(res_valid == 1'b0, "R9 drained", 64'(res_valid), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule